// File: doc/BRIEF.md
# Data Memory Address Generation Unit

This unit sits on the load/store path of a small 8-bit processor. It turns a memory request into an effective address in a unified 16-bit data space. The request names an addressing mode, a pointer, a displacement and a direct address. The unit owns the 32-byte working register file, and that file holds the three 16-bit pointers.

The unit decodes the address into one of three regions: the working registers, a 64-byte I/O window, or internal SRAM. It then drives the matching select together with the offset inside that region. The block runs the access as a short sequence of one or two cycles. When the mode calls for it, the unit writes the moved pointer back into the register file.

Load results go to a destination register in the file, and `ld_data` also shows them for one cycle. Stores present their byte on `mem_wdata` to the selected region. A store aimed at the register region lands directly in the file.

Top module: `dmag_top`

## Requirements
- R1: Mode code 0 (direct) uses `req_addr` as the effective address over the whole 16-bit space. It never changes a pointer. The pointer selector has no effect in this mode.
- R2: Mode code 1 (indirect) uses the selected pointer as the address and leaves it unchanged. The selector codes are 0, 1 and 2, and they read the register pairs 26/27, 28/29 and 30/31. The even register of each pair is the low byte. Selector code 3 makes the access unmapped.
- R3: Mode code 2 (displacement) adds the unsigned 6-bit `req_disp` to the pointer, which must be selector 1 or 2, and leaves the pointer unchanged. Selector 0 or 3 makes the access unmapped. Mode codes 5 to 7 also give an unmapped access.
- R4: Mode code 3 (pre-decrement) subtracts one from the pointer modulo 2^16. The result is used as the address and is also written back to the pointer.
- R5: Mode code 4 (post-increment) uses the old pointer as the address and then writes back the pointer plus one, modulo 2^16.
- R6: Addresses 0x0000–0x001F raise `sel_rf`, with the offset equal to the address. Addresses 0x0020–0x005F raise `sel_io`, with the offset equal to the address minus 0x20. Addresses from 0x0060 to the top of SRAM raise `sel_sram`, with the offset equal to the address minus 0x60. At most one select is high at a time.
- R7: The top of SRAM is 0x0060 + `SRAM_BYTES` − 1. An address above it, or an unmapped access, raises no select and no `mem_we`. Such an access completes in one cycle, a load from it returns 0x00, and a store to it has no effect.
- R8: A register or I/O access holds its select for one cycle, and `ready` is high in that same cycle, which is the cycle after acceptance. An SRAM access holds `sel_sram` for two cycles, and `ready` is high in the second.
- R9: `ready` is a single-cycle pulse. The unit accepts a request only while `busy` is low. A request presented while the unit is busy is dropped.
- R10: A load writes its byte into register `req_dst`. A store to the register region writes `req_wdata` into the addressed register. Both writes take effect as the access completes. Such a write wins over the pointer write-back for the same byte. After reset, all registers read 0x00.
- R11: In the completing cycle of a pre-decrement or post-increment access, `ptr_wb_en` pulses. The same cycle shows the pointer selector on `ptr_wb_sel` and the new 16-bit value on `ptr_wb_val`. Both bytes are updated in that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_mode | input | 3 | Addressing mode code |
| req_ptr | input | 2 | Pointer selector |
| req_disp | input | 6 | Unsigned displacement |
| req_addr | input | 16 | Direct address |
| req_dst | input | 5 | Load destination register |
| req_wdata | input | 8 | Store data |
| io_rdata | input | 8 | Read data from the I/O region |
| sram_rdata | input | 8 | Read data from SRAM |
| busy | output | 1 | An access is in progress |
| ready | output | 1 | Access completes this cycle |
| sel_rf | output | 1 | Register region selected |
| sel_io | output | 1 | I/O region selected |
| sel_sram | output | 1 | SRAM region selected |
| mem_we | output | 1 | Write to the selected region |
| mem_off | output | 16 | Offset inside the selected region |
| mem_wdata | output | 8 | Store data toward the region |
| ld_data | output | 8 | Loaded byte, valid with ready |
| ptr_wb_en | output | 1 | Pointer write-back pulse |
| ptr_wb_sel | output | 2 | Pointer being written back |
| ptr_wb_val | output | 16 | New pointer value |

## Verification
The bench builds the unit with the default `SRAM_BYTES` of 128, which puts the top of SRAM at 0x00DF. With that value a direct access reaches the last SRAM byte and the first unmapped address, 0x00E0, one step apart. A pointer set to 0xFFFF or 0x0000 then covers both wrap directions, and those accesses fall into the unmapped space. The small address map also lets a displacement of 63 from a pointer in the I/O window land on the top I/O byte.

// File: rtl/dmag_pkg.sv
package dmag_pkg;

    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int RF_N    = 32;
    localparam int RF_IW   = $clog2(RF_N);
    localparam int DISP_W  = 6;
    localparam int PSEL_W  = 2;
    localparam int MODE_W  = 3;

    localparam logic [ADDR_W-1:0] IO_BASE   = 16'h0020;
    localparam logic [ADDR_W-1:0] SRAM_BASE = 16'h0060;
    localparam logic [RF_IW-1:0]  PTR_BASE  = 5'd26;

    typedef enum logic [MODE_W-1:0] {
        MD_DIRECT  = 3'd0,
        MD_IND     = 3'd1,
        MD_DISP    = 3'd2,
        MD_PREDEC  = 3'd3,
        MD_POSTINC = 3'd4
    } mode_e;

    typedef enum logic [PSEL_W-1:0] {
        PS_X = 2'd0,
        PS_Y = 2'd1,
        PS_Z = 2'd2,
        PS_BAD = 2'd3
    } ptrsel_e;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_RF   = 2'd1,
        RG_IO   = 2'd2,
        RG_SRAM = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_FIRST  = 2'd1,
        SQ_SECOND = 2'd2
    } seq_e;

    typedef struct packed {
        logic [ADDR_W-1:0] ea;
        logic [ADDR_W-1:0] ptr_new;
        logic              ptr_upd;
        logic              unmapped;
    } ea_t;

    typedef struct packed {
        region_e           region;
        logic [ADDR_W-1:0] off;
    } dec_t;

    function automatic logic [RF_IW-1:0] ptr_lo_idx(input logic [PSEL_W-1:0] s);
        return PTR_BASE + {{(RF_IW-PSEL_W-1){1'b0}}, s, 1'b0};
    endfunction

endpackage

// File: rtl/dmag_regfile.sv
module dmag_regfile
    import dmag_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [PSEL_W-1:0]   ptr_rsel,
    output logic [ADDR_W-1:0]   ptr_rval,
    input  logic [RF_IW-1:0]    rd_idx,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                pwe,
    input  logic [PSEL_W-1:0]   pwsel,
    input  logic [ADDR_W-1:0]   pwval,
    input  logic                gwe,
    input  logic [RF_IW-1:0]    gidx,
    input  logic [DATA_W-1:0]   gdata
);

    logic [DATA_W-1:0] regs [RF_N];
    logic [RF_IW-1:0]  rlo;
    logic [RF_IW-1:0]  wlo;

    assign rlo = ptr_lo_idx(ptr_rsel);
    assign wlo = ptr_lo_idx(pwsel);

    always_comb begin
        if (ptr_rsel == PS_BAD)
            ptr_rval = '0;
        else
            ptr_rval = {regs[rlo + RF_IW'(1)], regs[rlo]};
    end

    assign rd_data = regs[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RF_N; i++) regs[i] <= '0;
        end else begin
            for (int i = 0; i < RF_N; i++) begin
                if (gwe && gidx == RF_IW'(i))
                    regs[i] <= gdata;
                else if (pwe && wlo == RF_IW'(i))
                    regs[i] <= pwval[DATA_W-1:0];
                else if (pwe && (wlo + RF_IW'(1)) == RF_IW'(i))
                    regs[i] <= pwval[ADDR_W-1:DATA_W];
            end
        end
    end

    AST_PTR_PAIR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        pwe |-> (pwsel != PS_BAD)) else $error("pointer write with reserved selector"); // R11

endmodule

// File: rtl/dmag_ea.sv
module dmag_ea
    import dmag_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [PSEL_W-1:0] psel,
    input  logic [DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] ptr,
    output ea_t               res
);

    logic bad_ptr;
    assign bad_ptr = (psel == PS_BAD);

    always_comb begin
        res          = '0;
        res.ptr_new  = ptr;
        case (mode)
            MD_DIRECT: begin
                res.ea = addr;
            end
            MD_IND: begin
                res.ea       = ptr;
                res.unmapped = bad_ptr;
            end
            MD_DISP: begin
                res.ea       = ptr + {{(ADDR_W-DISP_W){1'b0}}, disp};
                res.unmapped = !(psel == PS_Y || psel == PS_Z);
            end
            MD_PREDEC: begin
                res.ea       = ptr - 16'd1;
                res.ptr_new  = ptr - 16'd1;
                res.ptr_upd  = !bad_ptr;
                res.unmapped = bad_ptr;
            end
            MD_POSTINC: begin
                res.ea       = ptr;
                res.ptr_new  = ptr + 16'd1;
                res.ptr_upd  = !bad_ptr;
                res.unmapped = bad_ptr;
            end
            default: begin
                res.unmapped = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dmag_decode.sv
module dmag_decode
    import dmag_pkg::*;
#(
    parameter int SRAM_BYTES = 128
) (
    input  logic [ADDR_W-1:0] ea,
    input  logic              unmapped,
    output dec_t              dec
);

    localparam logic [ADDR_W-1:0] SRAM_TOP = SRAM_BASE + ADDR_W'(SRAM_BYTES) - 16'd1;

    always_comb begin
        dec = '0;
        if (unmapped) begin
            dec.region = RG_NONE;
        end else if (ea < IO_BASE) begin
            dec.region = RG_RF;
            dec.off    = ea;
        end else if (ea < SRAM_BASE) begin
            dec.region = RG_IO;
            dec.off    = ea - IO_BASE;
        end else if (ea <= SRAM_TOP) begin
            dec.region = RG_SRAM;
            dec.off    = ea - SRAM_BASE;
        end
    end

endmodule

// File: rtl/dmag_seq.sv
module dmag_seq
    import dmag_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic is_sram,
    output logic accept,
    output logic busy,
    output logic ready
);

    seq_e state, state_nx;

    assign busy   = (state != SQ_IDLE);
    assign accept = (state == SQ_IDLE) && req_valid;
    assign ready  = ((state == SQ_FIRST) && !is_sram) || (state == SQ_SECOND);

    always_comb begin
        state_nx = state;
        case (state)
            SQ_IDLE:   if (req_valid) state_nx = SQ_FIRST;
            SQ_FIRST:  state_nx = is_sram ? SQ_SECOND : SQ_IDLE;
            SQ_SECOND: state_nx = SQ_IDLE;
            default:   state_nx = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SQ_IDLE;
        else     state <= state_nx;
    end

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready) else $error("ready longer than one cycle"); // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!busy && !req_valid) |=> !busy) else $error("left idle without request"); // R9

endmodule

// File: rtl/dmag_top.sv
module dmag_top
    import dmag_pkg::*;
#(
    parameter int SRAM_BYTES = 128
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_store,
    input  logic [2:0]  req_mode,
    input  logic [1:0]  req_ptr,
    input  logic [5:0]  req_disp,
    input  logic [15:0] req_addr,
    input  logic [4:0]  req_dst,
    input  logic [7:0]  req_wdata,
    input  logic [7:0]  io_rdata,
    input  logic [7:0]  sram_rdata,
    output logic        busy,
    output logic        ready,
    output logic        sel_rf,
    output logic        sel_io,
    output logic        sel_sram,
    output logic        mem_we,
    output logic [15:0] mem_off,
    output logic [7:0]  mem_wdata,
    output logic [7:0]  ld_data,
    output logic        ptr_wb_en,
    output logic [1:0]  ptr_wb_sel,
    output logic [15:0] ptr_wb_val
);

    logic [ADDR_W-1:0] ptr_cur;
    logic [DATA_W-1:0] rf_rd;
    ea_t               ea_res;
    dec_t              dec_now;
    logic              accept;

    dec_t              q_dec;
    logic              q_store;
    logic [RF_IW-1:0]  q_dst;
    logic [DATA_W-1:0] q_wdata;
    logic [PSEL_W-1:0] q_psel;
    logic [ADDR_W-1:0] q_ptr_new;
    logic              q_ptr_upd;

    logic [DATA_W-1:0] rdata_mux;
    logic              gwe;
    logic [RF_IW-1:0]  gidx;
    logic [DATA_W-1:0] gdata;

    dmag_ea u_ea (
        .mode (req_mode),
        .psel (req_ptr),
        .disp (req_disp),
        .addr (req_addr),
        .ptr  (ptr_cur),
        .res  (ea_res)
    );

    dmag_decode #(.SRAM_BYTES(SRAM_BYTES)) u_dec (
        .ea       (ea_res.ea),
        .unmapped (ea_res.unmapped),
        .dec      (dec_now)
    );

    dmag_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .is_sram   (q_dec.region == RG_SRAM),
        .accept    (accept),
        .busy      (busy),
        .ready     (ready)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q_dec     <= '0;
            q_store   <= 1'b0;
            q_dst     <= '0;
            q_wdata   <= '0;
            q_psel    <= '0;
            q_ptr_new <= '0;
            q_ptr_upd <= 1'b0;
        end else if (accept) begin
            q_dec     <= dec_now;
            q_store   <= req_store;
            q_dst     <= req_dst;
            q_wdata   <= req_wdata;
            q_psel    <= req_ptr;
            q_ptr_new <= ea_res.ptr_new;
            q_ptr_upd <= ea_res.ptr_upd;
        end
    end

    assign sel_rf    = busy && (q_dec.region == RG_RF);
    assign sel_io    = busy && (q_dec.region == RG_IO);
    assign sel_sram  = busy && (q_dec.region == RG_SRAM);
    assign mem_we    = busy && q_store && (q_dec.region != RG_NONE);
    assign mem_off   = busy ? q_dec.off : '0;
    assign mem_wdata = mem_we ? q_wdata : '0;

    always_comb begin
        case (q_dec.region)
            RG_RF:   rdata_mux = rf_rd;
            RG_IO:   rdata_mux = io_rdata;
            RG_SRAM: rdata_mux = sram_rdata;
            default: rdata_mux = '0;
        endcase
    end

    assign ld_data = (ready && !q_store) ? rdata_mux : '0;

    assign gwe   = ready && (!q_store || (q_dec.region == RG_RF));
    assign gidx  = q_store ? q_dec.off[RF_IW-1:0] : q_dst;
    assign gdata = q_store ? q_wdata : rdata_mux;

    assign ptr_wb_en  = ready && q_ptr_upd;
    assign ptr_wb_sel = ptr_wb_en ? q_psel : '0;
    assign ptr_wb_val = ptr_wb_en ? q_ptr_new : '0;

    dmag_regfile u_rf (
        .clk      (clk),
        .rst      (rst),
        .ptr_rsel (req_ptr),
        .ptr_rval (ptr_cur),
        .rd_idx   (q_dec.off[RF_IW-1:0]),
        .rd_data  (rf_rd),
        .pwe      (ptr_wb_en),
        .pwsel    (q_psel),
        .pwval    (q_ptr_new),
        .gwe      (gwe),
        .gidx     (gidx),
        .gdata    (gdata)
    );

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_rf, sel_io, sel_sram})) else $error("several selects"); // R6
    AST_IO_OFF_RANGE: assert property (@(posedge clk) disable iff (rst)
        sel_io |-> (mem_off < 16'd64)) else $error("io offset out of window"); // R6
    AST_SRAM_TWO_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (sel_sram && !ready) |=> (sel_sram && ready)) else $error("sram phase broken"); // R8
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ready && !mem_we && !sel_rf && !sel_io && !sel_sram) |-> (ld_data == 8'h00))
        else $error("unmapped load not zero"); // R7
    AST_WB_WITH_READY: assert property (@(posedge clk) disable iff (rst)
        ptr_wb_en |-> ready) else $error("write-back outside completion"); // R11
    AST_REQ_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(q_dec)) else $error("request taken while busy"); // R9

endmodule

// File: tb/dmag_top_bench.sv
`timescale 1ns/1ps
module dmag_top_bench;

    localparam int SB = 128;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_store;
    logic [2:0]  req_mode;
    logic [1:0]  req_ptr;
    logic [5:0]  req_disp;
    logic [15:0] req_addr;
    logic [4:0]  req_dst;
    logic [7:0]  req_wdata;
    logic [7:0]  io_rdata, sram_rdata;
    logic        busy, ready, sel_rf, sel_io, sel_sram, mem_we;
    logic [15:0] mem_off;
    logic [7:0]  mem_wdata, ld_data;
    logic        ptr_wb_en;
    logic [1:0]  ptr_wb_sel;
    logic [15:0] ptr_wb_val;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int m_rf [32];

    always #4 clk = ~clk;

    assign io_rdata   = 8'h40 ^ {2'b00, mem_off[5:0]};
    assign sram_rdata = mem_off[7:0] ^ 8'hC3;

    dmag_top #(.SRAM_BYTES(SB)) u_dmag_top (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
        .req_mode(req_mode), .req_ptr(req_ptr), .req_disp(req_disp),
        .req_addr(req_addr), .req_dst(req_dst), .req_wdata(req_wdata),
        .io_rdata(io_rdata), .sram_rdata(sram_rdata), .busy(busy),
        .ready(ready), .sel_rf(sel_rf), .sel_io(sel_io), .sel_sram(sel_sram),
        .mem_we(mem_we), .mem_off(mem_off), .mem_wdata(mem_wdata),
        .ld_data(ld_data), .ptr_wb_en(ptr_wb_en), .ptr_wb_sel(ptr_wb_sel),
        .ptr_wb_val(ptr_wb_val)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        check(req, "idle selects", int'({sel_rf, sel_io, sel_sram}), 0);
        check(req, "idle ready", int'(ready), 0);
        check(req, "idle busy", int'(busy), 0);
        check(req, "idle wb", int'(ptr_wb_en), 0);
    endtask

    // One access: drive at an idle negedge, compare every cycle with the model.
    task automatic access(input bit st, input int md, input int ps, input int dp,
                          input int ad, input int dst, input int wd,
                          input bit inject, input string tag);
        logic [15:0] ptr, ea, nptr;
        bit upd, ill;
        int rg, off, rdv, cycles;
        ptr  = (ps < 3) ? 16'(m_rf[26+2*ps] + 256*m_rf[27+2*ps]) : 16'h0;
        nptr = ptr; upd = 0; ill = 0;
        case (md)
            0: ea = 16'(ad);
            1: begin ea = ptr; ill = (ps == 3); end
            2: begin ea = ptr + 16'(dp); ill = !(ps == 1 || ps == 2); end
            3: begin ea = ptr - 16'd1; nptr = ea; ill = (ps == 3); upd = !ill; end
            4: begin ea = ptr; nptr = ptr + 16'd1; ill = (ps == 3); upd = !ill; end
            default: begin ea = 16'h0; ill = 1; end
        endcase
        off = 0;
        if (ill) rg = 0;
        else if (ea < 16'h20) begin rg = 1; off = int'(ea); end
        else if (ea < 16'h60) begin rg = 2; off = int'(ea) - 32; end
        else if (int'(ea) <= 96 + SB - 1) begin rg = 3; off = int'(ea) - 96; end
        else rg = 0;
        case (rg)
            1: rdv = m_rf[off];
            2: rdv = 8'h40 ^ off;
            3: rdv = (off ^ 8'hC3) & 255;
            default: rdv = 0;
        endcase
        cycles = (rg == 3) ? 2 : 1;

        req_store = st; req_mode = 3'(md); req_ptr = 2'(ps); req_disp = 6'(dp);
        req_addr = 16'(ad); req_dst = 5'(dst); req_wdata = 8'(wd); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 1; c <= cycles; c++) begin
            bit rdy;
            if (c > 1) @(negedge clk);
            rdy = (c == cycles);
            check(tag, "busy", int'(busy), 1);
            check(tag, "selects", int'({sel_rf, sel_io, sel_sram}),
                  (rg == 1) ? 4 : (rg == 2) ? 2 : (rg == 3) ? 1 : 0);
            check(tag, "offset", int'(mem_off), off);
            check(tag, "mem_we", int'(mem_we), int'(st && rg != 0));
            check(tag, "mem_wdata", int'(mem_wdata), (st && rg != 0) ? (wd & 255) : 0);
            check(tag, "ready", int'(ready), int'(rdy));
            check(tag, "ld_data", int'(ld_data), (rdy && !st) ? rdv : 0);
            check(tag, "ptr_wb_en", int'(ptr_wb_en), int'(rdy && upd));
            if (rdy && upd) begin
                check(tag, "ptr_wb_sel", int'(ptr_wb_sel), ps);
                check(tag, "ptr_wb_val", int'(ptr_wb_val), int'(nptr));
            end
            if (inject && c == 1 && cycles == 2) begin
                req_store = 1'b0; req_mode = 3'd0; req_addr = 16'h0025;
                req_dst = 5'd9; req_valid = 1'b1;
            end else begin
                req_valid = 1'b0;
            end
        end
        req_valid = 1'b0;
        if (upd) begin
            m_rf[26+2*ps] = int'(nptr[7:0]);
            m_rf[27+2*ps] = int'(nptr[15:8]);
        end
        if (!st) m_rf[dst] = rdv;
        else if (rg == 1) m_rf[off] = wd & 255;
        @(negedge clk);
        check_idle(tag);
    endtask

    task automatic set_ptr(input int ps, input int val);
        access(1, 0, 0, 0, 26 + 2*ps, 0, val & 255, 0, "R10");
        access(1, 0, 0, 0, 27 + 2*ps, 0, (val >> 8) & 255, 0, "R10");
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) m_rf[i] = 0;
        rst = 1'b1; req_valid = 1'b0; req_store = 1'b0; req_mode = '0; req_ptr = '0;
        req_disp = '0; req_addr = '0; req_dst = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_idle("R9");
        check("R9", "reset mem_off", int'(mem_off), 0);
        check("R9", "reset ld_data", int'(ld_data), 0);

        access(0, 0, 0, 0, 5, 1, 0, 0, "R10");            // reset register reads 0
        access(0, 0, 2, 0, 16'h0025, 3, 0, 0, "R1");        // direct io load, selector ignored
        access(0, 0, 0, 0, 16'h0070, 4, 0, 0, "R8");        // direct sram load, two cycles
        access(0, 0, 0, 0, 16'h00DF, 4, 0, 0, "R6");        // last sram byte
        access(0, 0, 0, 0, 16'h00E0, 6, 0, 0, "R7");        // first unmapped address
        access(1, 0, 0, 0, 16'h00E0, 0, 8'h77, 0, "R7");    // store ignored
        access(0, 0, 0, 0, 16'h0020, 7, 0, 0, "R6");        // first io byte
        access(1, 0, 0, 0, 16'h005F, 0, 8'h5A, 0, "R6");    // last io byte store
        access(0, 0, 0, 0, 16'h0060, 8, 0, 0, "R6");        // first sram byte
        access(0, 0, 0, 0, 16'hFFFF, 8, 0, 0, "R1");        // direct at top of space

        set_ptr(0, 16'h0060);
        access(0, 1, 0, 0, 0, 10, 0, 0, "R2");              // indirect through X
        access(1, 4, 0, 0, 0, 0, 8'hA1, 0, "R5");           // post-increment store
        access(0, 4, 0, 0, 0, 11, 0, 0, "R5");              // again, X -> 0x62
        access(0, 3, 0, 0, 0, 12, 0, 0, "R4");              // pre-decrement
        access(0, 0, 0, 0, 26, 13, 0, 0, "R11");            // read back X low byte
        access(0, 0, 0, 0, 27, 14, 0, 0, "R11");            // read back X high byte

        set_ptr(1, 16'h0020);
        access(0, 2, 1, 63, 0, 15, 0, 0, "R3");             // Y+63 -> 0x5F
        access(0, 2, 1, 0, 0, 15, 0, 0, "R3");              // Y+0
        access(0, 2, 0, 5, 0, 16, 0, 0, "R3");              // X not allowed
        access(0, 5, 1, 0, 0, 16, 0, 0, "R3");              // reserved mode
        access(0, 1, 3, 0, 0, 17, 0, 0, "R2");              // reserved selector

        set_ptr(2, 16'hFFFF);
        access(0, 4, 2, 0, 0, 18, 0, 0, "R5");              // wraps to 0x0000
        access(0, 3, 2, 0, 0, 18, 0, 0, "R4");              // wraps to 0xFFFF
        access(0, 2, 2, 16, 0, 19, 0, 0, "R3");             // Z+16 wraps to 0x000F, register region
        access(0, 3, 2, 0, 0, 19, 0, 0, "R4");

        set_ptr(2, 16'h0030);
        access(0, 4, 2, 0, 0, 30, 0, 0, "R10");             // load into Z low beats update
        access(0, 0, 0, 0, 30, 20, 0, 0, "R10");
        access(0, 0, 0, 0, 31, 21, 0, 0, "R10");
        access(0, 1, 2, 0, 0, 22, 0, 0, "R2");

        set_ptr(0, 16'h0080);
        access(0, 1, 0, 0, 0, 23, 0, 1, "R9");              // request while busy dropped
        access(1, 4, 0, 0, 0, 0, 8'h3C, 1, "R9");
        access(0, 0, 0, 0, 23, 24, 0, 0, "R9");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule